// File: doc/BRIEF.md
# Console CPU Bus Address Decoder

This block sits between an 8-bit CPU with a 16-bit address bus and the devices on that bus. For every access it chooses exactly one target: the 2 KB work RAM, the video-unit register window, the audio/IO register block, a disabled test range, a programmable cartridge mapper register window, or general cartridge space. It also folds mirrored ranges back onto their canonical local addresses. The work RAM array is inside the block. Reads from the external targets come back through per-device data inputs.

Read data is registered, so the CPU sees the byte one cycle after its read strobe. The block also tracks the last value driven on the data bus. A read from the disabled test range returns that value, which models an undriven (open) bus.

Top module: `bus_map_decoder`

## Requirements
- R1: An access at address $0000–$1FFF selects the RAM (tgt_sel bit 0) with loc_addr = address bits 10:0, zero-extended. All four 2 KB mirrors reach the same byte, so data written through one mirror is read back through any other.
- R2: An access at $2000–$3FFF selects the video window (tgt_sel bit 1) with loc_addr = address bits 2:0.
- R3: An access at $4000–$4017 selects the audio/IO block (tgt_sel bit 2) with loc_addr = address − $4000.
- R4: An access at $4018–$401F selects the test range (tgt_sel bit 3) with loc_addr = address − $4018. Writes there change no RAM byte, and reads there return the open-bus value of R10.
- R5: An access at $4020–$FFFF that the mapper window does not claim selects cartridge space (tgt_sel bit 5) with loc_addr equal to the full address.
- R6: A write with win_en high, win_lo ≤ address ≤ win_hi and address ≥ $4020 selects the mapper window (tgt_sel bit 4), which takes priority over cartridge space. Reads in the window go to cartridge space. The window never claims an address below $4020, and with win_en low it claims nothing.
- R7: While cpu_rd or cpu_wr is high, exactly one bit of tgt_sel is set. When both are low, tgt_sel is zero. The two strobes are never high together.
- R8: rdata and rvalid change only on the clock edge that samples cpu_rd. rvalid is high for exactly the cycle after each read strobe, and rdata holds its value when there is no read.
- R9: A write to the video, audio/IO, mapper, cartridge or test target leaves every RAM byte unchanged.
- R10: The open-bus value is the data of the most recent write (of any target) or the value returned by the most recent read.
- R11: After reset, rdata is $00, rvalid is low and the open-bus value is $00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| win_en | input | 1 | Mapper register window enable |
| win_lo | input | 16 | First address of the mapper window |
| win_hi | input | 16 | Last address of the mapper window |
| vid_rdata | input | 8 | Read byte from the video unit |
| io_rdata | input | 8 | Read byte from the audio/IO block |
| mreg_rdata | input | 8 | Read byte from the mapper registers |
| cart_rdata | input | 8 | Read byte from cartridge space |
| tgt_sel | output | 6 | One-hot target select (bit 0 RAM … bit 5 cartridge) |
| loc_addr | output | 16 | Folded local address for the selected target |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | Read data valid, one cycle after cpu_rd |

## Verification
The mapper window and ordinary cartridge decode both match any address above $4020 inside the window. Both decisions are therefore made in the same cycle, and only the priority between them keeps the select one-hot. The bench provokes this by writing at both ends of the window and then reading the same addresses. The write must raise only bit 4 and the read only bit 5. A window placed below $4020 must still lose to the IO decode. A second overlap is between the open-bus tracker and the read path: a test-range read directly after a read or a write must return exactly the byte of that previous access.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

   typedef enum logic [2:0] {
      T_RAM  = 3'd0,
      T_VID  = 3'd1,
      T_IO   = 3'd2,
      T_TEST = 3'd3,
      T_MREG = 3'd4,
      T_CART = 3'd5
   } tgt_e;

   localparam int N_TGT = 6;

endpackage

// File: rtl/bmd_decode.sv
module bmd_decode
   import bmd_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int RAM_AW    = 11,
   parameter int VID_AW    = 3,
   parameter int VID_BASE  = 'h2000,
   parameter int IO_BASE   = 'h4000,
   parameter int TEST_BASE = 'h4018,
   parameter int CART_BASE = 'h4020,
   parameter bit WIN_RD    = 1'b0
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic              win_en,
   input  logic [ADDR_W-1:0] win_lo,
   input  logic [ADDR_W-1:0] win_hi,
   output tgt_e              tgt,
   output logic [N_TGT-1:0]  sel,
   output logic [ADDR_W-1:0] loc
);

   localparam logic [ADDR_W-1:0] VID_B  = ADDR_W'(VID_BASE);
   localparam logic [ADDR_W-1:0] IO_B   = ADDR_W'(IO_BASE);
   localparam logic [ADDR_W-1:0] TEST_B = ADDR_W'(TEST_BASE);
   localparam logic [ADDR_W-1:0] CART_B = ADDR_W'(CART_BASE);

   logic access;
   logic win_claim;
   logic win_hit;

   assign access = rd_en | wr_en;

   generate
      if (WIN_RD) begin : g_win_rw
         assign win_claim = win_en;
      end else begin : g_win_wo
         assign win_claim = win_en & wr_en;
      end
   endgenerate

   assign win_hit = win_claim && (addr >= win_lo) && (addr <= win_hi);

   always_comb begin
      tgt = T_CART;
      loc = addr;
      if (addr < VID_B) begin
         tgt = T_RAM;
         loc = ADDR_W'(addr[RAM_AW-1:0]);
      end else if (addr < IO_B) begin
         tgt = T_VID;
         loc = ADDR_W'(addr[VID_AW-1:0]);
      end else if (addr < TEST_B) begin
         tgt = T_IO;
         loc = addr - IO_B;
      end else if (addr < CART_B) begin
         tgt = T_TEST;
         loc = addr - TEST_B;
      end else if (win_hit) begin
         tgt = T_MREG;
      end
   end

   for (genvar i = 0; i < N_TGT; i++) begin : g_sel
      assign sel[i] = access && (int'(tgt) == i);
   end

endmodule

// File: rtl/bmd_ram.sv
module bmd_ram #(
   parameter int AW = 11,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign q = mem[addr];

endmodule

// File: rtl/bmd_rdmux.sv
module bmd_rdmux
   import bmd_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          wr_en,
   input  tgt_e          tgt,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] ram_q,
   input  logic [DW-1:0] vid_q,
   input  logic [DW-1:0] io_q,
   input  logic [DW-1:0] mreg_q,
   input  logic [DW-1:0] cart_q,
   output logic [DW-1:0] rdata,
   output logic          rvalid
);

   logic [DW-1:0] bus_last;
   logic [DW-1:0] pick;

   always_comb begin
      unique case (tgt)
         T_RAM:   pick = ram_q;
         T_VID:   pick = vid_q;
         T_IO:    pick = io_q;
         T_TEST:  pick = bus_last;
         T_MREG:  pick = mreg_q;
         default: pick = cart_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata    <= '0;
         rvalid   <= 1'b0;
         bus_last <= '0;
      end else begin
         rvalid <= rd_en;
         if (rd_en) begin
            rdata    <= pick;
            bus_last <= pick;
         end else if (wr_en) begin
            bus_last <= wdata;
         end
      end
   end

endmodule

// File: rtl/bus_map_decoder.sv
module bus_map_decoder
   import bmd_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter int RAM_AW    = 11,
   parameter int VID_AW    = 3,
   parameter int VID_BASE  = 'h2000,
   parameter int IO_BASE   = 'h4000,
   parameter int TEST_BASE = 'h4018,
   parameter int CART_BASE = 'h4020,
   parameter bit WIN_RD    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic              win_en,
   input  logic [ADDR_W-1:0] win_lo,
   input  logic [ADDR_W-1:0] win_hi,
   input  logic [DATA_W-1:0] vid_rdata,
   input  logic [DATA_W-1:0] io_rdata,
   input  logic [DATA_W-1:0] mreg_rdata,
   input  logic [DATA_W-1:0] cart_rdata,
   output logic [N_TGT-1:0]  tgt_sel,
   output logic [ADDR_W-1:0] loc_addr,
   output logic [DATA_W-1:0] rdata,
   output logic              rvalid
);

   localparam longint ADDR_SPAN = longint'(1) << ADDR_W;

   generate
      if (RAM_AW >= ADDR_W) begin : g_bad_ram
         $error("RAM_AW must be narrower than ADDR_W");
      end
      if (VID_AW >= ADDR_W) begin : g_bad_vid
         $error("VID_AW must be narrower than ADDR_W");
      end
      if (!(VID_BASE < IO_BASE && IO_BASE < TEST_BASE && TEST_BASE < CART_BASE)) begin : g_bad_order
         $error("region bases must ascend");
      end
      if (longint'(CART_BASE) >= ADDR_SPAN) begin : g_bad_cart
         $error("cartridge base outside address space");
      end
   endgenerate

   tgt_e            tgt;
   logic [DATA_W-1:0] ram_q;
   logic            ram_we;

   bmd_decode #(
      .ADDR_W   (ADDR_W),
      .RAM_AW   (RAM_AW),
      .VID_AW   (VID_AW),
      .VID_BASE (VID_BASE),
      .IO_BASE  (IO_BASE),
      .TEST_BASE(TEST_BASE),
      .CART_BASE(CART_BASE),
      .WIN_RD   (WIN_RD)
   ) u_dec (
      .addr  (cpu_addr),
      .rd_en (cpu_rd),
      .wr_en (cpu_wr),
      .win_en(win_en),
      .win_lo(win_lo),
      .win_hi(win_hi),
      .tgt   (tgt),
      .sel   (tgt_sel),
      .loc   (loc_addr)
   );

   assign ram_we = cpu_wr & tgt_sel[T_RAM];

   bmd_ram #(
      .AW(RAM_AW),
      .DW(DATA_W)
   ) u_ram (
      .clk  (clk),
      .we   (ram_we),
      .addr (cpu_addr[RAM_AW-1:0]),
      .wdata(cpu_wdata),
      .q    (ram_q)
   );

   bmd_rdmux #(
      .DW(DATA_W)
   ) u_rdm (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_en (cpu_rd),
      .wr_en (cpu_wr),
      .tgt   (tgt),
      .wdata (cpu_wdata),
      .ram_q (ram_q),
      .vid_q (vid_rdata),
      .io_q  (io_rdata),
      .mreg_q(mreg_rdata),
      .cart_q(cart_rdata),
      .rdata (rdata),
      .rvalid(rvalid)
   );

endmodule

// File: rtl/bmd_checks.sv
module bmd_checks #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int NT     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic              win_en,
   input logic [ADDR_W-1:0] win_lo,
   input logic [ADDR_W-1:0] win_hi,
   input logic [NT-1:0]     tgt_sel,
   input logic [ADDR_W-1:0] loc_addr,
   input logic [DATA_W-1:0] rdata,
   input logic              rvalid
);

   logic acc;
   assign acc = cpu_rd | cpu_wr;

   p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      acc |-> $countones(tgt_sel) == 1);

   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |-> tgt_sel == '0);

   p_rvalid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rd |=> rvalid);

   p_rvalid_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> !rvalid);

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(rdata));

   p_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cpu_addr < ADDR_W'('h2000)) |-> (tgt_sel[0] && loc_addr[ADDR_W-1:11] == '0));

   p_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && win_en && cpu_addr >= win_lo && cpu_addr <= win_hi
       && cpu_addr >= ADDR_W'('h4020)) |-> tgt_sel[4]);

   p_window_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && cpu_addr >= ADDR_W'('h4020)) |-> tgt_sel[5]);

endmodule

bind bus_map_decoder bmd_checks #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W),
   .NT    (bmd_pkg::N_TGT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cpu_addr(cpu_addr),
   .cpu_rd  (cpu_rd),
   .cpu_wr  (cpu_wr),
   .win_en  (win_en),
   .win_lo  (win_lo),
   .win_hi  (win_hi),
   .tgt_sel (tgt_sel),
   .loc_addr(loc_addr),
   .rdata   (rdata),
   .rvalid  (rvalid)
);

// File: tb/sim_bus_map_decoder.sv
module sim_bus_map_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic        win_en = 1'b0;
   logic [15:0] win_lo = '0;
   logic [15:0] win_hi = '0;
   logic [7:0]  vid_rdata = 8'h5A;
   logic [7:0]  io_rdata = 8'h3C;
   logic [7:0]  mreg_rdata = 8'h77;
   logic [7:0]  cart_rdata = 8'hC3;
   logic [5:0]  tgt_sel;
   logic [15:0] loc_addr;
   logic [7:0]  rdata;
   logic        rvalid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bus_map_decoder u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_wdata (cpu_wdata),
      .cpu_rd    (cpu_rd),
      .cpu_wr    (cpu_wr),
      .win_en    (win_en),
      .win_lo    (win_lo),
      .win_hi    (win_hi),
      .vid_rdata (vid_rdata),
      .io_rdata  (io_rdata),
      .mreg_rdata(mreg_rdata),
      .cart_rdata(cart_rdata),
      .tgt_sel   (tgt_sel),
      .loc_addr  (loc_addr),
      .rdata     (rdata),
      .rvalid    (rvalid)
   );

   // {write, addr, wdata, expected sel, expected loc, expected read byte}
   localparam int NV = 25;
   localparam logic [54:0] VEC [NV] = '{
      {1'b1, 16'h0005, 8'h11, 6'b000001, 16'h0005, 8'h00},
      {1'b0, 16'h1805, 8'h00, 6'b000001, 16'h0005, 8'h11},  // mirror
      {1'b1, 16'h0FFF, 8'h22, 6'b000001, 16'h07FF, 8'h00},
      {1'b0, 16'h07FF, 8'h00, 6'b000001, 16'h07FF, 8'h22},
      {1'b0, 16'h2000, 8'h00, 6'b000010, 16'h0000, 8'h5A},
      {1'b0, 16'h3FFF, 8'h00, 6'b000010, 16'h0007, 8'h5A},
      {1'b1, 16'h2005, 8'hEE, 6'b000010, 16'h0005, 8'h00},
      {1'b0, 16'h0005, 8'h00, 6'b000001, 16'h0005, 8'h11},  // R9 after video write
      {1'b0, 16'h4017, 8'h00, 6'b000100, 16'h0017, 8'h3C},
      {1'b1, 16'h4000, 8'h33, 6'b000100, 16'h0000, 8'h00},
      {1'b1, 16'h6000, 8'h99, 6'b010000, 16'h6000, 8'h00},  // window write
      {1'b0, 16'h6000, 8'h00, 6'b100000, 16'h6000, 8'hC3},  // window read to cart
      {1'b1, 16'h8005, 8'hEE, 6'b100000, 16'h8005, 8'h00},
      {1'b0, 16'h0805, 8'h00, 6'b000001, 16'h0005, 8'h11},  // R9 after cart write
      {1'b0, 16'h4020, 8'h00, 6'b100000, 16'h4020, 8'hC3},
      {1'b1, 16'h7FFF, 8'h44, 6'b010000, 16'h7FFF, 8'h00},
      {1'b0, 16'h401F, 8'h00, 6'b001000, 16'h0007, 8'h44},  // R10 last write
      {1'b0, 16'h2000, 8'h00, 6'b000010, 16'h0000, 8'h5A},
      {1'b0, 16'h4018, 8'h00, 6'b001000, 16'h0000, 8'h5A},  // R10 last read
      {1'b1, 16'h0018, 8'h12, 6'b000001, 16'h0018, 8'h00},
      {1'b1, 16'h4018, 8'h55, 6'b001000, 16'h0000, 8'h00},
      {1'b0, 16'h4019, 8'h00, 6'b001000, 16'h0001, 8'h55},
      {1'b0, 16'h0018, 8'h00, 6'b000001, 16'h0018, 8'h12},  // R4 write ignored
      {1'b1, 16'h1FFF, 8'h66, 6'b000001, 16'h07FF, 8'h00},
      {1'b0, 16'h07FF, 8'h00, 6'b000001, 16'h07FF, 8'h66}
   };

   function automatic string req_of(input logic [5:0] s);
      case (s)
         6'b000001: return "R1";
         6'b000010: return "R2";
         6'b000100: return "R3";
         6'b001000: return "R4";
         6'b010000: return "R6";
         default:   return "R5";
      endcase
   endfunction

   task automatic check(input string rq, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s: got %h expected %h", rq, got, exp);
      end
   endtask

   task automatic do_op(input logic w, input logic [15:0] a, input logic [7:0] d,
                        input logic [5:0] es, input logic [15:0] el, input logic [7:0] er,
                        input string rq);
      @(negedge clk);
      cpu_rd = !w;
      cpu_wr = w;
      cpu_addr = a;
      cpu_wdata = d;
      #1;
      check({rq, " R7 sel"}, 16'(tgt_sel), 16'(es));
      check({rq, " loc"}, loc_addr, el);
      @(negedge clk);
      cpu_rd = 1'b0;
      cpu_wr = 1'b0;
      if (!w) begin
         check("R8 rvalid", 16'(rvalid), 16'd1);
         check({rq, " rdata"}, 16'(rdata), 16'(er));
      end
   endtask

   task automatic report;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      #800000;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 rdata", 16'(rdata), 16'h00);
      check("R11 rvalid", 16'(rvalid), 16'd0);
      check("R7 idle sel", 16'(tgt_sel), 16'd0);
      rst_n = 1'b1;
      // R11 open bus starts at zero
      do_op(1'b0, 16'h4018, 8'h00, 6'b001000, 16'h0000, 8'h00, "R11 open bus");

      win_en = 1'b1;
      win_lo = 16'h6000;
      win_hi = 16'h7FFF;
      for (int i = 0; i < NV; i++) begin
         logic [54:0] v;
         v = VEC[i];
         do_op(v[54], v[53:38], v[37:30], v[29:24], v[23:8], v[7:0], req_of(v[29:24]));
      end

      // R8: rvalid drops and rdata holds with no read
      @(negedge clk);
      check("R8 rvalid low", 16'(rvalid), 16'd0);
      check("R8 rdata hold", 16'(rdata), 16'h66);
      check("R7 idle sel", 16'(tgt_sel), 16'd0);

      // R6: disabled window claims nothing
      win_en = 1'b0;
      do_op(1'b1, 16'h6000, 8'h01, 6'b100000, 16'h6000, 8'h00, "R6 disabled");
      // R6: window below cartridge base does not steal IO or RAM
      win_en = 1'b1;
      win_lo = 16'h0000;
      win_hi = 16'h4FFF;
      do_op(1'b1, 16'h4010, 8'h02, 6'b000100, 16'h0010, 8'h00, "R6 low window");
      do_op(1'b1, 16'h0005, 8'h77, 6'b000001, 16'h0005, 8'h00, "R6 low window ram");
      do_op(1'b1, 16'h4020, 8'h03, 6'b010000, 16'h4020, 8'h00, "R6 low edge");
      do_op(1'b1, 16'h5000, 8'h04, 6'b100000, 16'h5000, 8'h00, "R6 above hi");
      do_op(1'b0, 16'h0005, 8'h00, 6'b000001, 16'h0005, 8'h77, "R1 readback");

      // R11: reset clears read data
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R11 rdata after reset", 16'(rdata), 16'h00);
      @(negedge clk);
      rst_n = 1'b1;
      do_op(1'b0, 16'h401A, 8'h00, 6'b001000, 16'h0002, 8'h00, "R11 open bus cleared");

      report();
   end

endmodule